// File: doc/BRIEF.md
# FPGA Serial Configuration Sequencer

This block loads a configuration image into an FPGA that waits passively for its bitstream. On a start pulse from the host it runs a fixed sequence. It emits a one-cycle preparation strobe. It pulls the target's configuration request line inactive for a timed reset window and then returns it to active. It waits a short settling time and then polls the target's status input, giving up after a timeout. While the target reports ready, it streams image bytes from a valid/ready byte source. After the last byte it checks the target's configuration-done input, and on success it emits a one-cycle completion strobe.

The data path runs in one of two modes, and both modes share the control sequence. In serial mode each byte leaves least significant bit first on bit 0 of the data pins, with one data-clock pulse per bit. In parallel mode the whole byte sits on the data pins for a single data-clock pulse. The mode is latched when a start is accepted. Every fault runs the same abort action and leaves a latched error code. A request to read the configuration back is refused with its own error code. All intervals are parameters given in system clock cycles.

Top module: `fpga_cfg_seq`

## Requirements
- R1: Out of reset the block is idle: `cfg_req_o`=1, `tgt_d_o`=0, `tgt_dclk_o`=0, and `busy_o`, `done_o`, `err_o`, `err_code_o`, `in_ready_o` are all 0.
- R2: An accepted start (`start_i`=1, `readback_i`=0 while idle) raises `busy_o` and pulses `pre_strobe_o` for exactly one cycle. On the next cycle `cfg_req_o` goes to 0 and stays there for exactly RESET_CYC cycles, after which it returns to 1.
- R3: No data is requested (`in_ready_o`=0) until more than SETTLE_CYC cycles after `cfg_req_o` returns to 1. The status input is then polled, and 1 means ready.
- R4: If `tgt_status_i` is still 0 after SETTLE_CYC+TIMEOUT_CYC cycles from the request going active, the block aborts with `err_code_o`=1 (status timeout).
- R5: In serial mode (`mode_par_i`=0) each byte is sent LSB first on `tgt_d_o[0]` with `tgt_d_o[7:1]`=0. There is exactly one rising edge of `tgt_dclk_o` per bit, and the data is stable for at least one system cycle before each rising edge.
- R6: In parallel mode (`mode_par_i`=1) each byte appears on `tgt_d_o[7:0]` and is marked by exactly one rising edge of `tgt_dclk_o`, with the same set-up rule.
- R7: If `tgt_status_i` drops to 0 while data is being streamed, the block aborts with `err_code_o`=2 (write failure).
- R8: One cycle after the last bit or byte (flagged by `in_last_i`), `tgt_done_i` is sampled. A 0 aborts with `err_code_o`=3. A 1 pulses `post_strobe_o` for one cycle, then sets `done_o`=1 with `err_code_o`=0.
- R9: A start with `readback_i`=1 is refused: the block stays idle, no strobe is emitted, the request line does not move, and `err_code_o`=4.
- R10: `done_o` and the error code (`err_o` = error code nonzero) hold until the next start pulse taken while idle, which clears them. A start pulse while busy is ignored.
- R11: Any abort and any normal completion leaves `cfg_req_o`=1, `tgt_d_o`=0, `tgt_dclk_o`=0 and `busy_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse |
| mode_par_i | input | 1 | 0 = serial, 1 = byte-wide parallel |
| readback_i | input | 1 | Readback request (always refused) |
| in_data_i | input | 8 | Image byte |
| in_valid_i | input | 1 | Image byte valid |
| in_last_i | input | 1 | Marks the final image byte |
| in_ready_o | output | 1 | Sequencer accepts an image byte |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence completed successfully |
| err_o | output | 1 | Latched error present |
| err_code_o | output | 3 | 0 none, 1 status timeout, 2 write failure, 3 done missing, 4 readback refused |
| pre_strobe_o | output | 1 | One-cycle strobe before the reset window |
| post_strobe_o | output | 1 | One-cycle strobe after a successful done check |
| cfg_req_o | output | 1 | Configuration request to target, 0 = inactive (reset), 1 = active |
| tgt_status_i | input | 1 | Target status, 1 = ready |
| tgt_done_i | input | 1 | Target configuration done, 1 = done |
| tgt_d_o | output | 8 | Data to target (bit 0 only in serial mode) |
| tgt_dclk_o | output | 1 | Data clock to target |

## Verification
The bench builds the block with RESET_CYC=6, SETTLE_CYC=3, TIMEOUT_CYC=25 and DCLK_HALF=1. These values shrink the millisecond-scale windows to a few cycles. The exact reset width, the settle gap and the whole timeout path can then be measured cycle by cycle. The short bit period leaves room for an exhaustive sweep of all 256 byte values in serial mode and again in parallel mode. The sweep is decoded by a bench-side target model. The bench also forces each abort path and the readback refusal, and exercises the latching and the ignored start around them.

// File: rtl/fcs_pkg.sv
// Shared types for the configuration sequencer.
// Assumes: one byte-wide image source; error codes are visible at the ports.
package fcs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_RESET,
        ST_SETTLE,
        ST_POLL,
        ST_STREAM,
        ST_CHECK,
        ST_POST
    } seq_state_t;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_TIMEOUT  = 3'd1,
        ERR_WRITE    = 3'd2,
        ERR_CONF     = 3'd3,
        ERR_READBACK = 3'd4
    } err_code_t;

endpackage

// File: rtl/fcs_interval_timer.sv
// Interval timer: counts cycles from a restart and flags the last cycle of
// a window whose length is given by `limit`. It saturates once expired.
// Assumes: limit >= 1; restart is asserted on the cycle before a window starts.
module fcs_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Expiry is flagged on the final cycle of the window.
    assign expired = (cnt_q == limit - W'(1));

    // Count up from zero after every restart and hold at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/fcs_data_shifter.sv
// Data shifter: takes one byte per handshake and drives it to the target.
// Serial mode sends LSB first on bit 0, one clock pulse per bit. Parallel
// mode sends the whole byte with one clock pulse. Each clock phase lasts
// HALF system cycles, and data always leads the rising edge by a full low
// phase.
// Assumes: HALF >= 1; en low clears all state (used for abort).
module fcs_data_shifter #(
    parameter int DW   = 8,
    parameter int HALF = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          par_mode,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    input  logic          in_last,
    output logic          in_ready,
    output logic [DW-1:0] pin_data,
    output logic          pin_clk,
    output logic          fin
);

    localparam int BW = $clog2(DW + 1);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [DW-1:0] sh_q;
    logic [BW-1:0] left_q;
    logic [HW-1:0] pcnt_q;
    logic          phase_q;
    logic          last_q;
    logic          fin_q;
    logic          active;

    assign active   = (left_q != '0);
    assign in_ready = en && !active;
    assign pin_clk  = active && phase_q;
    assign fin      = fin_q;

    // Present the whole byte in parallel mode, only bit 0 in serial mode.
    always_comb begin
        pin_data = '0;
        if (active) begin
            if (par_mode) begin
                pin_data = sh_q;
            end else begin
                pin_data[0] = sh_q[0];
            end
        end
    end

    // Load a byte, step the clock phases, and shift out one unit per pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sh_q    <= '0;
            left_q  <= '0;
            pcnt_q  <= '0;
            phase_q <= 1'b0;
            last_q  <= 1'b0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (in_ready && in_valid) begin
                sh_q    <= in_data;
                left_q  <= par_mode ? BW'(1) : BW'(DW);
                last_q  <= in_last;
                phase_q <= 1'b0;
                pcnt_q  <= '0;
            end else if (active) begin
                if (pcnt_q == HW'(HALF - 1)) begin
                    pcnt_q  <= '0;
                    phase_q <= ~phase_q;
                    if (phase_q) begin
                        sh_q   <= sh_q >> 1;
                        left_q <= left_q - BW'(1);
                        if (left_q == BW'(1) && last_q) begin
                            fin_q <= 1'b1;
                        end
                    end
                end else begin
                    pcnt_q <= pcnt_q + HW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/fpga_cfg_seq.sv
// Configuration sequencer top. It runs the timed target handshake:
// preparation strobe, reset window, settle, status poll with timeout,
// streaming, done check and completion strobe. Every fault goes through a
// single abort path back to idle with a latched error code.
// Assumes: intervals are given in system clock cycles, each at least 1.
module fpga_cfg_seq #(
    parameter int RESET_CYC   = 10000,
    parameter int SETTLE_CYC  = 200,
    parameter int TIMEOUT_CYC = 10000000,
    parameter int DCLK_HALF   = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      mode_par_i,
    input  logic                      readback_i,
    input  logic [fcs_pkg::BYTE_W-1:0] in_data_i,
    input  logic                      in_valid_i,
    input  logic                      in_last_i,
    output logic                      in_ready_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      err_o,
    output logic [2:0]                err_code_o,
    output logic                      pre_strobe_o,
    output logic                      post_strobe_o,
    output logic                      cfg_req_o,
    input  logic                      tgt_status_i,
    input  logic                      tgt_done_i,
    output logic [fcs_pkg::BYTE_W-1:0] tgt_d_o,
    output logic                      tgt_dclk_o
);

    import fcs_pkg::*;

    localparam int MAX_AB = (RESET_CYC > SETTLE_CYC) ? RESET_CYC : SETTLE_CYC;
    localparam int MAX_C  = (MAX_AB > TIMEOUT_CYC) ? MAX_AB : TIMEOUT_CYC;
    localparam int TW     = $clog2(MAX_C + 1);

    seq_state_t          st_q, st_d;
    err_code_t           err_q;
    logic                done_q;
    logic                par_q;
    logic [TW-1:0]       win_len;
    logic                win_exp;
    logic                sh_fin;
    logic                sh_ready;
    logic [BYTE_W-1:0]   sh_data;
    logic                sh_clk;
    logic                streaming;

    assign streaming = (st_q == ST_STREAM);

    // Pick the window length that belongs to the timed state.
    always_comb begin
        unique case (st_q)
            ST_RESET:  win_len = TW'(RESET_CYC);
            ST_SETTLE: win_len = TW'(SETTLE_CYC);
            default:   win_len = TW'(TIMEOUT_CYC);
        endcase
    end

    fcs_interval_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (st_d != st_q),
        .limit   (win_len),
        .expired (win_exp)
    );

    fcs_data_shifter #(.DW(BYTE_W), .HALF(DCLK_HALF)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (streaming),
        .par_mode (par_q),
        .in_data  (in_data_i),
        .in_valid (in_valid_i),
        .in_last  (in_last_i),
        .in_ready (sh_ready),
        .pin_data (sh_data),
        .pin_clk  (sh_clk),
        .fin      (sh_fin)
    );

    // Next-state sequencing; every failure branch returns to idle (abort).
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start_i && !readback_i) st_d = ST_PRE;
            ST_PRE:    st_d = ST_RESET;
            ST_RESET:  if (win_exp) st_d = ST_SETTLE;
            ST_SETTLE: if (win_exp) st_d = ST_POLL;
            ST_POLL: begin
                if (tgt_status_i)  st_d = ST_STREAM;
                else if (win_exp)  st_d = ST_IDLE;
            end
            ST_STREAM: begin
                if (!tgt_status_i) st_d = ST_IDLE;
                else if (sh_fin)   st_d = ST_CHECK;
            end
            ST_CHECK:  st_d = tgt_done_i ? ST_POST : ST_IDLE;
            ST_POST:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Latch the mode, the outcome and the error code; clear them on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= ERR_NONE;
            done_q <= 1'b0;
            par_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        done_q <= 1'b0;
                        err_q  <= readback_i ? ERR_READBACK : ERR_NONE;
                        if (!readback_i) par_q <= mode_par_i;
                    end
                end
                ST_POLL:   if (!tgt_status_i && win_exp) err_q <= ERR_TIMEOUT;
                ST_STREAM: if (!tgt_status_i) err_q <= ERR_WRITE;
                ST_CHECK:  if (!tgt_done_i) err_q <= ERR_CONF;
                ST_POST:   done_q <= 1'b1;
                default:   ;
            endcase
        end
    end

    assign busy_o        = (st_q != ST_IDLE);
    assign done_o        = done_q;
    assign err_code_o    = err_q;
    assign err_o         = (err_q != ERR_NONE);
    assign pre_strobe_o  = (st_q == ST_PRE);
    assign post_strobe_o = (st_q == ST_POST);
    assign cfg_req_o     = (st_q != ST_RESET);
    assign in_ready_o    = streaming && sh_ready;
    assign tgt_d_o       = streaming ? sh_data : '0;
    assign tgt_dclk_o    = streaming && sh_clk;

endmodule

// File: rtl/fcs_checker.sv
// Property checker for the configuration sequencer, bound to every instance.
// Assumes: it sees the top's ports plus the latched mode flag.
module fcs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic [2:0] err_code_o,
    input logic       pre_strobe_o,
    input logic       post_strobe_o,
    input logic       cfg_req_o,
    input logic [7:0] tgt_d_o,
    input logic       tgt_dclk_o,
    input logic       par_q
);

    // R2: the request line is only inactive inside a running sequence.
    assert_req_low_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_req_o |-> busy_o);

    // R2: a sequence always opens with the preparation strobe.
    assert_pre_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> pre_strobe_o);

    // R2: the reset window follows the preparation strobe directly.
    assert_pre_then_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_strobe_o |=> !cfg_req_o);

    // R5: data is stable across the cycle leading into a data-clock rise.
    assert_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_dclk_o) |-> $stable(tgt_d_o));

    // R5: serial mode keeps the upper data lines at zero.
    assert_serial_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !par_q |-> (tgt_d_o[7:1] == 7'd0));

    // R8: the completion strobe is followed by the done flag.
    assert_post_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        post_strobe_o |=> (done_o && err_code_o == 3'd0));

    // R8: the two strobes never coincide.
    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_strobe_o, post_strobe_o}));

    // R10: the error code holds in idle unless a start arrives.
    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(err_code_o));

    // R11: when idle the target pins are parked.
    assert_idle_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cfg_req_o && tgt_d_o == 8'd0 && !tgt_dclk_o));

endmodule

bind fpga_cfg_seq fcs_checker u_fcs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_code_o    (err_code_o),
    .pre_strobe_o  (pre_strobe_o),
    .post_strobe_o (post_strobe_o),
    .cfg_req_o     (cfg_req_o),
    .tgt_d_o       (tgt_d_o),
    .tgt_dclk_o    (tgt_dclk_o),
    .par_q         (par_q)
);

// File: tb/fpga_cfg_seq_bench.sv
// Bench: a target model on the pins, exhaustive byte sweeps in both modes,
// and forced fault paths. Inputs change after the rising edge; everything
// is sampled on the falling edge.
module fpga_cfg_seq_bench;

    localparam int RC = 6;
    localparam int SC = 3;
    localparam int TC = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, mode_par_i = 1'b0, readback_i = 1'b0;
    logic [7:0] in_data_i = 8'd0;
    logic       in_valid_i = 1'b0, in_last_i = 1'b0;
    logic       in_ready_o, busy_o, done_o, err_o;
    logic [2:0] err_code_o;
    logic       pre_strobe_o, post_strobe_o, cfg_req_o;
    logic       tgt_status_i = 1'b0, tgt_done_i = 1'b0;
    logic [7:0] tgt_d_o;
    logic       tgt_dclk_o;

    always #4 clk = ~clk;

    fpga_cfg_seq #(.RESET_CYC(RC), .SETTLE_CYC(SC), .TIMEOUT_CYC(TC), .DCLK_HALF(1))
    u_fpga_cfg_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_par_i(mode_par_i),
        .readback_i(readback_i), .in_data_i(in_data_i), .in_valid_i(in_valid_i),
        .in_last_i(in_last_i), .in_ready_o(in_ready_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o),
        .pre_strobe_o(pre_strobe_o), .post_strobe_o(post_strobe_o),
        .cfg_req_o(cfg_req_o), .tgt_status_i(tgt_status_i), .tgt_done_i(tgt_done_i),
        .tgt_d_o(tgt_d_o), .tgt_dclk_o(tgt_dclk_o)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;

    // Target model and monitor state.
    bit         par_model = 0, stat_never = 0, stat_kill = 0;
    logic [7:0] rx [0:511];
    int         rx_n = 0, scnt = 0;
    logic [7:0] sbuf = 0, pd = 0;
    logic       pdclk = 0, pcfg = 1, pbusy = 0;
    int         rise_cnt = 1000, low_len = 0, last_low = 0;
    int         pre_n = 0, post_n = 0, setup_err = 0, upper_err = 0;
    int         ready_lat = -1, fall_lat = -1;
    bit         busy_seen = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run is a failure and still reaches the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    // Target model: status follows the request line; pins are decoded on data-clock rises.
    always @(negedge clk) begin
        if (cfg_req_o && !pcfg) begin
            rise_cnt = 0;
            last_low = low_len;
            low_len  = 0;
        end else begin
            rise_cnt = rise_cnt + 1;
        end
        if (!cfg_req_o) low_len = low_len + 1;
        tgt_status_i = cfg_req_o && !stat_never && !stat_kill;
        if (pre_strobe_o)  pre_n++;
        if (post_strobe_o) post_n++;
        if (busy_o) busy_seen = 1;
        if (in_ready_o && ready_lat < 0) ready_lat = rise_cnt;
        if (!busy_o && pbusy) fall_lat = rise_cnt;
        if (tgt_dclk_o && !pdclk) begin
            if (tgt_d_o != pd) setup_err++;
            if (par_model) begin
                rx[rx_n] = tgt_d_o;
                rx_n++;
            end else begin
                if (tgt_d_o[7:1] != 7'd0) upper_err++;
                sbuf = {tgt_d_o[0], sbuf[7:1]};
                scnt++;
                if (scnt == 8) begin
                    rx[rx_n] = sbuf;
                    rx_n++;
                    scnt = 0;
                end
            end
        end
        pdclk = tgt_dclk_o;
        pd    = tgt_d_o;
        pcfg  = cfg_req_o;
        pbusy = busy_o;
    end

    task automatic pulse_start(input bit rb);
        @(posedge clk); #1;
        start_i = 1; readback_i = rb;
        @(posedge clk); #1;
        start_i = 0; readback_i = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit last);
        @(posedge clk); #1;
        in_data_i = b; in_last_i = last; in_valid_i = 1;
        forever begin
            @(negedge clk);
            if (in_ready_o) begin
                @(posedge clk); #1;
                break;
            end
            if (!busy_o) break;
        end
        in_valid_i = 0; in_last_i = 0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
    endtask

    function automatic logic [7:0] pat(input int i, input bit par);
        return par ? 8'((i * 37 + 11) & 255) : 8'(i);
    endfunction

    // One sequence: n bytes, an optional status drop before byte `drop`,
    // and an optional extra start while busy.
    task automatic run(input bit par, input int n, input bit done_ok, input int drop,
                       input bit extra_start, input bit never);
        @(posedge clk); #1;
        rx_n = 0; scnt = 0; pre_n = 0; post_n = 0; setup_err = 0; upper_err = 0;
        ready_lat = -1; fall_lat = -1; busy_seen = 0; last_low = 0;
        par_model = par; stat_never = never; stat_kill = 0;
        mode_par_i = par; tgt_done_i = done_ok;
        pulse_start(0);
        if (extra_start) begin
            repeat (2) @(posedge clk);
            #1 start_i = 1;
            @(posedge clk); #1 start_i = 0;
        end
        if (!never) begin
            for (int i = 0; i < n; i++) begin
                if (i == drop) begin
                    @(posedge clk); #1 stat_kill = 1;
                end
                if (!busy_o) break;
                send_byte(pat(i, par), i == n - 1);
            end
        end
        wait_idle();
        @(negedge clk);
    endtask

    function automatic int rx_mismatch(input bit par, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) if (rx[i] !== pat(i, par)) bad++;
        return bad;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(cfg_req_o == 1 && tgt_d_o == 0 && tgt_dclk_o == 0, "R1 pins in reset", cfg_req_o, 1);
        @(posedge clk); #1 rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !done_o && !err_o && err_code_o == 0 && !in_ready_o,
            "R1 idle status", {busy_o, done_o, err_o}, 0);

        // Serial sweep of all 256 byte values.
        run(0, 256, 1, -1, 0, 0);
        chk(rx_n == 256, "R5 serial byte count", rx_n, 256);
        chk(rx_mismatch(0, 256) == 0, "R5 serial LSB-first data", rx_mismatch(0, 256), 0);
        chk(setup_err == 0, "R5 serial setup", setup_err, 0);
        chk(upper_err == 0, "R5 serial upper lines", upper_err, 0);
        chk(pre_n == 1, "R2 one pre strobe", pre_n, 1);
        chk(last_low == RC, "R2 reset window width", last_low, RC);
        chk(ready_lat > SC, "R3 settle before data", ready_lat, SC + 1);
        chk(done_o && err_code_o == 0, "R8 success done", {done_o, err_code_o}, 8);
        chk(post_n == 1, "R8 one post strobe", post_n, 1);
        chk(cfg_req_o && tgt_d_o == 0 && !tgt_dclk_o && !busy_o, "R11 parked after success",
            tgt_d_o, 0);

        // Parallel sweep of all 256 byte values.
        run(1, 256, 1, -1, 0, 0);
        chk(rx_n == 256, "R6 parallel byte count", rx_n, 256);
        chk(rx_mismatch(1, 256) == 0, "R6 parallel data", rx_mismatch(1, 256), 0);
        chk(setup_err == 0, "R6 parallel setup", setup_err, 0);
        chk(done_o && err_code_o == 0, "R6 parallel done", err_code_o, 0);

        // Status never ready: timeout.
        run(0, 1, 1, -1, 0, 1);
        chk(err_code_o == 1 && err_o, "R4 timeout code", err_code_o, 1);
        chk(fall_lat >= SC + TC && fall_lat <= SC + TC + 2, "R4 timeout latency", fall_lat, SC + TC);
        chk(!done_o && post_n == 0, "R4 no completion", post_n, 0);
        chk(cfg_req_o && tgt_d_o == 0 && !tgt_dclk_o && !busy_o, "R11 parked after timeout",
            cfg_req_o, 1);

        // Status drops while streaming: write failure.
        run(1, 8, 1, 3, 0, 0);
        chk(err_code_o == 2, "R7 write failure code", err_code_o, 2);
        chk(post_n == 0 && !done_o, "R7 no completion", post_n, 0);
        chk(rx_n <= 4, "R7 streaming stopped", rx_n, 3);
        chk(cfg_req_o && tgt_d_o == 0 && !busy_o, "R11 parked after write failure", tgt_d_o, 0);

        // Done input stays low: configuration failure.
        run(0, 3, 0, -1, 0, 0);
        chk(err_code_o == 3, "R8 done missing code", err_code_o, 3);
        chk(post_n == 0 && !done_o, "R8 no post strobe on failure", post_n, 0);
        repeat (10) @(negedge clk);
        chk(err_code_o == 3, "R10 error latched in idle", err_code_o, 3);

        // Next start clears the error; a second start while busy is ignored.
        run(1, 4, 1, -1, 1, 0);
        chk(pre_n == 1, "R10 start while busy ignored (pre)", pre_n, 1);
        chk(last_low == RC, "R10 start while busy ignored (width)", last_low, RC);
        chk(done_o && err_code_o == 0, "R10 error cleared by new start", err_code_o, 0);
        chk(rx_mismatch(1, 4) == 0 && rx_n == 4, "R10 data intact", rx_n, 4);

        // Readback refused.
        @(posedge clk); #1 pre_n = 0; busy_seen = 0;
        pulse_start(1);
        repeat (5) @(negedge clk);
        chk(err_code_o == 4 && err_o, "R9 readback refused code", err_code_o, 4);
        chk(!busy_seen && pre_n == 0 && cfg_req_o, "R9 no sequence", pre_n, 0);
        chk(!done_o, "R10 done cleared by start", done_o, 0);

        finish_run();
    end

endmodule